// File: doc/BRIEF.md
# Digit-Serial Modular Multiplier

This block computes the product of two residues modulo a runtime modulus, `Z = X·Y mod M`, for N-bit operands. It works from the most significant end of `Y`, taking D bits per cycle. Before the digit loop starts, it builds a small table of residues of `X` multiplied by successive powers of two, one new entry per cycle. On each loop cycle the running remainder is multiplied by 2^D and reduced. The table entries that the current digit selects are then added in with a carry-save adder tree, and the total is reduced back below `M`.

Every doubling step keeps its value below `M` without a division. It doubles, then adds the two's complement of `M` with the carry out dropped. It does this when the doubled value overflows N bits or is not below `M`. The reduction after the digit sum takes off `M` times successive powers of two, largest first. Only simple adders and comparators appear in the datapath.

A caller applies `modulus`, `op_x` and `op_y` and pulses `start`. One cycle pulse on `done` marks the result on `result`. The result stays there until the next operation completes. A host uses the block as the inner step of modular exponentiation or point arithmetic.

Top module: `mm_digit_serial`

## Requirements
- R1: When `done` is high, `result` equals (`op_x`·`op_y`) mod `modulus` for the operands sampled with `start`. This holds for any modulus of at least 1 and any operands below it, including zero, one and modulus−1.
- R2: `done` is high for exactly one cycle. It rises D + ceil(N/D) clock edges after the edge that sampled `start`, counting that edge as the first.
- R3: `op_y` is consumed in D-bit digits, most significant digit first. When N is not a multiple of D, zero bits are added above bit N−1. A set bit in the top or the bottom position of `op_y` therefore weighs 2^(N−1) or 1 respectively.
- R4: The table holds D entries, and entry j equals `op_x`·2^j mod `modulus`. Entry 0 is loaded at `start` and each later entry is built from the one before, one per cycle. Every entry stays below the modulus.
- R5: During the digit loop, the running remainder and the reduced digit sum are both below the modulus.
- R6: A doubling step whose result carries out of bit N−1 or is not below the modulus is corrected by adding the two's complement of the modulus. The step result is then below the modulus, which holds for moduli with the top bit set.
- R7: After reset, `result` is 0 and `done` is 0. `result` changes only in the cycle where `done` is high, and otherwise holds even when the inputs change.
- R8: A `start` pulse while an operation is in progress is ignored. Changes to `modulus`, `op_x` and `op_y` during that time are also ignored, and the running operation finishes on time with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts an operation when idle |
| modulus | input | N | Modulus, sampled with start |
| op_x | input | N | Multiplicand, below modulus |
| op_y | input | N | Multiplier scanned by digits, below modulus |
| result | output | N | Product residue |
| done | output | 1 | One-cycle pulse when result is fresh |

## Verification
The one result of each operation is due D + ceil(N/D) rising edges after the edge that takes `start`. The bench drives inputs and samples outputs only on falling edges. It numbers each falling edge after the start edge, so a result sampled at falling edge k has had exactly k rising edges. Four copies with D = 1, 2, 3 and 4 run the same operations. Each copy's `done` must appear at exactly its own edge count and stay high for one cycle only. The bench then checks `result` a few cycles later against a 64-bit reference product taken modulo M, to confirm the value is held.

// File: rtl/mm_pkg.sv
package mm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_RUN  = 2'd2
    } mm_state_e;

endpackage

// File: rtl/mm_dbl.sv
// One modular doubling: r = 2a mod m for a < m. Overflow is folded by adding
// the two's complement of m and dropping the carry.
module mm_dbl #(
    parameter int N = 32
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] m,
    output logic [N-1:0] r
);
    logic         carry;
    logic [N-1:0] low;
    logic [N-1:0] neg_m;

    always_comb begin
        carry = a[N-1];
        low   = {a[N-2:0], 1'b0};
        neg_m = (~m) + {{(N-1){1'b0}}, 1'b1};
        if (carry || (low >= m)) begin
            r = low + neg_m;
        end else begin
            r = low;
        end
    end
endmodule

// File: rtl/mm_csa.sv
// Multi-operand adder: a chain of 3:2 compressors and one final adder.
module mm_csa #(
    parameter int W = 35,
    parameter int T = 5
) (
    input  logic [T-1:0][W-1:0] terms,
    output logic [W-1:0]        sum
);
    logic [W-1:0] s_v [T+1];
    logic [W-1:0] c_v [T+1];

    assign s_v[0] = '0;
    assign c_v[0] = '0;

    for (genvar i = 0; i < T; i++) begin : g_stage
        assign s_v[i+1] = s_v[i] ^ c_v[i] ^ terms[i];
        assign c_v[i+1] = ((s_v[i] & c_v[i]) | (s_v[i] & terms[i]) | (c_v[i] & terms[i])) << 1;
    end

    assign sum = s_v[T] + c_v[T];
endmodule

// File: rtl/mm_reduce.sv
// Restoring reduction: v < 2^GB * m in, result < m out.
module mm_reduce #(
    parameter int N  = 32,
    parameter int GB = 3,
    localparam int W = N + GB
) (
    input  logic [W-1:0] v,
    input  logic [N-1:0] m,
    output logic [W-1:0] r
);
    logic [W-1:0] st_v [GB+1];

    assign st_v[0] = v;

    for (genvar i = 0; i < GB; i++) begin : g_sub
        logic [W-1:0] mk;
        assign mk        = {{GB{1'b0}}, m} << (GB - 1 - i);
        assign st_v[i+1] = (st_v[i] >= mk) ? (st_v[i] - mk) : st_v[i];
    end

    assign r = st_v[GB];
endmodule

// File: rtl/mm_digit_serial.sv
module mm_digit_serial
    import mm_pkg::*;
#(
    parameter int N = 32,
    parameter int D = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] modulus,
    input  logic [N-1:0] op_x,
    input  logic [N-1:0] op_y,
    output logic [N-1:0] result,
    output logic         done
);
    localparam int NDIG = (N + D - 1) / D;
    localparam int YW   = NDIG * D;
    localparam int GB   = $clog2(D + 1);
    localparam int W    = N + GB;
    localparam int KW   = $clog2(D + NDIG + 1);

    typedef struct packed {
        mm_state_e            st;
        logic [KW-1:0]        cnt;
        logic [N-1:0]         m;
        logic [N-1:0]         a;
        logic [YW-1:0]        y;
        logic [D-1:0][N-1:0]  s;
        logic [N-1:0]         tail;
        logic [N-1:0]         z;
        logic                 done;
    } regs_t;

    regs_t q, d;

    // table build: one doubling per cycle
    logic [N-1:0] pre_out;
    mm_dbl #(.N(N)) u_pre_dbl (.a(q.tail), .m(q.m), .r(pre_out));

    // remainder times 2^D: D chained doublings
    logic [N-1:0] sh_v [D+1];
    assign sh_v[0] = q.a;
    for (genvar k = 0; k < D; k++) begin : g_shift
        mm_dbl #(.N(N)) u_dbl (.a(sh_v[k]), .m(q.m), .r(sh_v[k+1]));
    end

    // digit-selected table entries plus shifted remainder
    logic [D-1:0]         digit;
    logic [D:0][W-1:0]    terms;
    logic [W-1:0]         dsum;
    logic [W-1:0]         red_w;
    logic [N-1:0]         red;

    always_comb begin
        digit    = q.y[YW-1 -: D];
        terms[0] = {{GB{1'b0}}, sh_v[D]};
        for (int j = 0; j < D; j++) begin
            terms[j+1] = digit[j] ? {{GB{1'b0}}, q.s[j]} : '0;
        end
    end

    mm_csa #(.W(W), .T(D + 1)) u_csa (.terms(terms), .sum(dsum));
    mm_reduce #(.N(N), .GB(GB)) u_red (.v(dsum), .m(q.m), .r(red_w));
    assign red = red_w[N-1:0];

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.m    = modulus;
                    d.s    = '0;
                    d.s[0] = op_x;
                    d.tail = op_x;
                    d.a    = '0;
                    d.y    = YW'(op_y);
                    if (D > 1) begin
                        d.st  = ST_PRE;
                        d.cnt = KW'(1);
                    end else begin
                        d.st  = ST_RUN;
                        d.cnt = '0;
                    end
                end
            end
            ST_PRE: begin
                for (int j = 1; j < D; j++) begin
                    if (q.cnt == KW'(j)) d.s[j] = pre_out;
                end
                d.tail = pre_out;
                if (q.cnt == KW'(D - 1)) begin
                    d.st  = ST_RUN;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + KW'(1);
                end
            end
            ST_RUN: begin
                d.a = red;
                d.y = q.y << D;
                if (q.cnt == KW'(NDIG - 1)) begin
                    d.st   = ST_IDLE;
                    d.cnt  = '0;
                    d.z    = red;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt + KW'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign result = q.z;
    assign done   = q.done;

    // ---------------- assertions ----------------
    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    for (genvar g = 0; g < D; g++) begin : g_tab_chk
        p_table_below_m_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (q.st == ST_RUN) |-> (q.s[g] < q.m));
    end

    p_rem_below_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |-> ((q.a < q.m) && (red_w < {{GB{1'b0}}, q.m})));

    p_fold_below_m_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_RUN) |-> (sh_v[D] < q.m));

    p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !q.done |-> $stable(q.z));

    p_busy_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st != ST_IDLE) && start) |=> $stable(q.m));
endmodule

// File: tb/mm_digit_serial_tb.sv
module mm_digit_serial_tb_top;
    localparam int CLK_NS = 10;
    localparam int NB     = 32;
    localparam int NI     = 4;
    localparam int DV [NI] = '{1, 2, 3, 4};
    localparam int MAXWAIT = 60;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NB-1:0] modulus = '0;
    logic [NB-1:0] op_x = '0;
    logic [NB-1:0] op_y = '0;
    logic [NB-1:0] z_w    [NI];
    logic          done_w [NI];

    int total = 0;
    int bad   = 0;

    always #(CLK_NS/2) clk = ~clk;

    for (genvar g = 0; g < NI; g++) begin : g_dut
        mm_digit_serial #(.N(NB), .D(DV[g])) dut_i (
            .clk(clk), .rst_n(rst_n), .start(start), .modulus(modulus),
            .op_x(op_x), .op_y(op_y), .result(z_w[g]), .done(done_w[g])
        );
    end

    function automatic logic [NB-1:0] ref_mod(input logic [NB-1:0] x, y, m);
        logic [63:0] p;
        p = {32'b0, x} * {32'b0, y};
        return NB'(p % {32'b0, m});
    endfunction

    function automatic int lat_of(input int dd);
        return dd + (NB + dd - 1) / dd;
    endfunction

    task automatic chk(input bit ok, input string req, input int inst,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s d=%0d actual=%0h expected=%0h", req, DV[inst], act, exp);
        end
    endtask

    // runs one operation on all copies; busy_poke drives a second start and new
    // operands while the copies are busy (R8)
    task automatic run_op(input logic [NB-1:0] x, y, m, input bit busy_poke, input string req);
        logic [NB-1:0] exp;
        int            lat   [NI];
        int            highs [NI];
        logic [NB-1:0] got   [NI];
        exp = ref_mod(x, y, m);
        @(negedge clk);
        op_x = x; op_y = y; modulus = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int g = 0; g < NI; g++) begin lat[g] = -1; highs[g] = 0; got[g] = '0; end
        for (int cyc = 1; cyc <= MAXWAIT; cyc++) begin
            for (int g = 0; g < NI; g++) begin
                if (done_w[g]) begin
                    highs[g]++;
                    if (lat[g] < 0) begin lat[g] = cyc; got[g] = z_w[g]; end
                end
            end
            if (busy_poke && cyc == 2) begin
                op_x = $urandom; op_y = $urandom; modulus = $urandom | 32'h1; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        for (int g = 0; g < NI; g++) begin
            chk(got[g] == exp, req, g, 64'(got[g]), 64'(exp));
            chk(lat[g] == lat_of(DV[g]), "R2 latency", g, 64'(lat[g]), 64'(lat_of(DV[g])));
            chk(highs[g] == 1, "R2 pulse", g, 64'(highs[g]), 64'd1);
        end
        // R7: inputs change without start; result must hold
        op_x = $urandom; op_y = $urandom; modulus = $urandom;
        repeat (3) @(negedge clk);
        for (int g = 0; g < NI; g++) begin
            chk(z_w[g] == exp, "R7 hold", g, 64'(z_w[g]), 64'(exp));
        end
    endtask

    initial begin
        #(CLK_NS * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NB-1:0] m, x, y;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        for (int g = 0; g < NI; g++) begin
            chk(z_w[g] == '0 && done_w[g] == 1'b0, "R7 reset", g, 64'(z_w[g]), 64'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int g = 0; g < NI; g++) begin
            chk(z_w[g] == '0 && done_w[g] == 1'b0, "R7 after reset", g, 64'(z_w[g]), 64'd0);
        end

        // directed corner cases
        run_op(32'd0, 32'h1234_5677 % 32'hFFFF_FFFB, 32'hFFFF_FFFB, 1'b0, "R1 x=0");
        run_op(32'h0ABC_DEF1, 32'd0, 32'hFFFF_FFFB, 1'b0, "R1 y=0");
        run_op(32'd1, 32'h8765_4321, 32'hFFFF_FFFB, 1'b0, "R1 x=1");
        run_op(32'h8765_4321, 32'd1, 32'hFFFF_FFFB, 1'b0, "R3 y=1 lowest digit");
        run_op(32'hFFFF_FFFA, 32'hFFFF_FFFA, 32'hFFFF_FFFB, 1'b0, "R6 x=y=m-1 large m");
        run_op(32'd12, 32'd12, 32'd13, 1'b0, "R1 x=y=m-1 small m");
        run_op(32'd0, 32'd0, 32'd1, 1'b0, "R1 m=1");
        run_op(32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 1'b0, "R3 top bit of y");
        run_op(32'hC000_0001, 32'hBFFF_FFFF, 32'hC000_0003, 1'b0, "R4 R6 carry doubling");
        run_op(32'h0F0F_0F0F, 32'h7070_7070, 32'hF123_4567, 1'b1, "R8 start while busy");

        // constrained random
        for (int i = 0; i < 30; i++) begin
            if (i % 2 == 0) m = $urandom | 32'h8000_0000;
            else            m = ($urandom % 32'h00FF_FFFF) + 32'd2;
            x = $urandom % m;
            y = $urandom % m;
            run_op(x, y, m, (i % 7 == 3), "R1 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule